// File: doc/BRIEF.md
# Debug Address-Match Trigger Unit

This unit holds a small bank of hardware watchpoints for a processor core. Software reaches it through four CSR-numbered registers. One register selects a trigger. Two more hold that trigger's configuration word and its match address. A fourth holds the machine-mode trigger enable and its saved copy.

Every cycle the core presents at most one access: a 32-bit address, a size code, strobes for load, store and fetch, and the current privilege level. The unit compares the access against every trigger in the same cycle, with no register on the path. It raises `fire` together with the index and the programmed action of the winning trigger, so the core can act before the access completes. The trigger that fires gets its sticky hit flag set at the next clock edge. Taking the exception or entering debug mode is left to the core.

Top module: `dbg_trig_unit`

## Requirements
- R1: CSR 0x7a0 holds the trigger index, which is the low 2 bits of the written value and reads back. CSRs 0x7a1 (config) and 0x7a2 (match address) read and write the selected trigger. CSR 0x7a5 is the control word. Unknown CSR numbers read 0, and every register resets to 0.
- R2: Config bit 0 enables loads, bit 1 stores and bit 2 fetches. Bit 3 enables the trigger for user privilege (`acc_priv`=00) and bit 6 for machine privilege (`acc_priv`=11). A trigger fires only when `acc_valid` is high, one enabled kind strobe is high and the privilege is enabled. Privilege codes 01 and 10 never fire.
- R3: Config bits 10:7 select the match type: 0 is exact, 1 is a naturally aligned region. A written value above 1 is stored as 1.
- R4: Config bits 15:12 hold the action. A written 1 is kept only if the resulting dmode bit is 1. Every other non-zero value is stored as 0. `fire_action` reports the winning trigger's action.
- R5: In exact mode a trigger matches when any byte of the access equals the match address. The access covers `acc_size` 0, 1 or 2, which is 1, 2 or 4 bytes starting at `acc_addr`. Size code 3 is treated as 4 bytes, and byte addresses wrap modulo 2^32.
- R6: In region mode, k trailing ones in the match address denote an aligned region of 2^(k+1) bytes whose base is the address with those k+1 low bits cleared. A trigger matches when any byte of the access lies in the region.
- R7: Config bit 20 is a sticky hit flag. The trigger that fires has it set at the next edge, and it stays set until software writes it to 0. If software clears it in the same cycle the trigger fires, the flag ends up set.
- R8: Config bit 27 is dmode, which only a write with `dbg_mode` high can change. While it is 1, writes to that trigger's config and address registers without `dbg_mode` are ignored.
- R9: Control bit 3 must be 1 for any trigger to fire at machine privilege. It has no effect at user privilege. Control bit 7 holds the saved copy.
- R10: `trap_enter` copies control bit 3 into bit 7 and clears bit 3. Otherwise `trap_return` copies bit 7 into bit 3. Either one overrides a CSR write to the control word in the same cycle.
- R11: `fire` is combinational in the access cycle. When several triggers match, the lowest index is reported and only that trigger's hit flag is set.
- R12: A trigger whose config word is all zeros never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR number for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| dbg_mode | input | 1 | Current write originates from debug mode |
| trap_enter | input | 1 | Core takes a trap into machine mode |
| trap_return | input | 1 | Core returns from a machine trap |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access start byte address |
| acc_size | input | 2 | Size code: 0=1, 1=2, 2=4 bytes |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| acc_exec | input | 1 | Access is an instruction fetch |
| acc_priv | input | 2 | Privilege: 00 user, 11 machine |
| fire | output | 1 | A trigger matches this access |
| fire_idx | output | IDX_W | Index of the winning trigger |
| fire_action | output | 4 | Action field of the winning trigger |

## Verification
Two cases of same-cycle events are exercised. In the first, a trigger fires in the same cycle that software writes that trigger's config word with the hit flag cleared. The expected result is a stored word that is the legalised write data with the hit flag set. In the second, a trap entry or return arrives in the same cycle as a write to the control word, and the trap update must win. Both cases are set up by driving the CSR write strobe together with an access or a trap pulse. The outcome is then judged by reading the affected register back in the next cycle, and a bench reference model predicts every output on every cycle.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   localparam logic [11:0] CSR_SEL = 12'h7a0;
   localparam logic [11:0] CSR_CFG = 12'h7a1;
   localparam logic [11:0] CSR_ADR = 12'h7a2;
   localparam logic [11:0] CSR_CTL = 12'h7a5;

   localparam int B_LD   = 0;
   localparam int B_ST   = 1;
   localparam int B_EX   = 2;
   localparam int B_U    = 3;
   localparam int B_M    = 6;
   localparam int MT_LO  = 7;
   localparam int MT_HI  = 10;
   localparam int AC_LO  = 12;
   localparam int AC_HI  = 15;
   localparam int B_HIT  = 20;
   localparam int B_DM   = 27;

   localparam int CTL_MTE  = 3;
   localparam int CTL_MPTE = 7;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_M = 2'b11;

   // Turn an arbitrary written value into a legal config word.
   function automatic logic [31:0] legal_cfg(input logic [31:0] wd,
                                             input logic [31:0] cur,
                                             input logic        dbg);
      logic [31:0] r;
      logic        dm;
      dm = dbg ? wd[B_DM] : cur[B_DM];
      r = '0;
      r[B_LD] = wd[B_LD];
      r[B_ST] = wd[B_ST];
      r[B_EX] = wd[B_EX];
      r[B_U]  = wd[B_U];
      r[B_M]  = wd[B_M];
      r[MT_HI:MT_LO] = (wd[MT_HI:MT_LO] > 4'd1) ? 4'd1 : wd[MT_HI:MT_LO];
      r[AC_HI:AC_LO] = (wd[AC_HI:AC_LO] == 4'd1 && dm) ? 4'd1 : 4'd0;
      r[B_HIT] = wd[B_HIT];
      r[B_DM]  = dm;
      return r;
   endfunction

endpackage

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
   import dbg_trig_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cfg,
   input  logic              wr_adr,
   input  logic [31:0]       wdata,
   input  logic              dbg_mode,
   input  logic              set_hit,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_load,
   input  logic              acc_store,
   input  logic              acc_exec,
   input  logic [1:0]        acc_priv,
   input  logic              mte,
   output logic [31:0]       cfg_q,
   output logic [ADDR_W-1:0] adr_q,
   output logic              hit_req
);

   logic              locked;
   logic [31:0]       cfg_d;
   logic [ADDR_W-1:0] nmask;
   logic              napot;
   logic [3:0]        nbytes;
   logic [MAX_BYTES-1:0] byte_hit;
   logic              kind_ok;
   logic              priv_ok;

   assign locked = cfg_q[B_DM] & ~dbg_mode;

   always_comb begin
      cfg_d = cfg_q;
      if (wr_cfg && !locked) cfg_d = legal_cfg(wdata, cfg_q, dbg_mode);
      if (set_hit) cfg_d[B_HIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         adr_q <= '0;
      end else begin
         cfg_q <= cfg_d;
         if (wr_adr && !locked) adr_q <= wdata[ADDR_W-1:0];
      end
   end

   // Trailing ones plus the following zero form the region mask.
   assign nmask  = adr_q ^ (adr_q + ADDR_W'(1));
   assign napot  = (cfg_q[MT_HI:MT_LO] == 4'd1);
   assign nbytes = 4'd1 << acc_size;

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      logic [ADDR_W-1:0] ba;
      logic              in_size;
      assign ba      = acc_addr + ADDR_W'(b);
      assign in_size = (4'(b) < nbytes);
      assign byte_hit[b] = in_size &
                           (napot ? (((ba ^ adr_q) & ~nmask) == '0) : (ba == adr_q));
   end

   assign kind_ok = (acc_load & cfg_q[B_LD]) | (acc_store & cfg_q[B_ST]) |
                    (acc_exec & cfg_q[B_EX]);
   assign priv_ok = ((acc_priv == PRIV_U) & cfg_q[B_U]) |
                    ((acc_priv == PRIV_M) & cfg_q[B_M] & mte);
   assign hit_req = acc_valid & kind_ok & priv_ok & (|byte_hit);

endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_mte,
   input  logic wr_mpte,
   input  logic trap_enter,
   input  logic trap_return,
   output logic mte,
   output logic mpte
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mte  <= 1'b0;
         mpte <= 1'b0;
      end else if (trap_enter) begin
         mpte <= mte;
         mte  <= 1'b0;
      end else if (trap_return) begin
         mte <= mpte;
      end else if (wr) begin
         mte  <= wr_mte;
         mpte <= wr_mpte;
      end
   end

endmodule

// File: rtl/dbg_trig_prio.sv
module dbg_trig_prio #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int NUM_TRIG  = 4,
   parameter int ADDR_W    = 32,
   parameter int MAX_BYTES = 4,
   localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [11:0]       csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              dbg_mode,
   input  logic              trap_enter,
   input  logic              trap_return,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_load,
   input  logic              acc_store,
   input  logic              acc_exec,
   input  logic [1:0]        acc_priv,
   output logic              fire,
   output logic [IDX_W-1:0]  fire_idx,
   output logic [3:0]        fire_action
);

   if (NUM_TRIG < 2 || (NUM_TRIG & (NUM_TRIG - 1)) != 0) begin : g_bad_num
      $error("NUM_TRIG must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W must lie between 8 and 32");
   end
   if (MAX_BYTES < 1 || MAX_BYTES > 8) begin : g_bad_mb
      $error("MAX_BYTES must lie between 1 and 8");
   end

   logic [IDX_W-1:0]  sel_q;
   logic [31:0]       cfg_arr [NUM_TRIG];
   logic [ADDR_W-1:0] adr_arr [NUM_TRIG];
   logic [NUM_TRIG-1:0] req;
   logic [NUM_TRIG-1:0] hit_vec;
   logic              mte;
   logic              mpte;
   logic              wr_cfg;
   logic              wr_adr;
   logic              wr_ctl;
   logic [31:0]       sel_cfg;

   assign wr_cfg = csr_we & (csr_addr == CSR_CFG);
   assign wr_adr = csr_we & (csr_addr == CSR_ADR);
   assign wr_ctl = csr_we & (csr_addr == CSR_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               sel_q <= '0;
      else if (csr_we && csr_addr == CSR_SEL)   sel_q <= csr_wdata[IDX_W-1:0];
   end

   dbg_trig_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (wr_ctl),
      .wr_mte      (csr_wdata[CTL_MTE]),
      .wr_mpte     (csr_wdata[CTL_MPTE]),
      .trap_enter  (trap_enter),
      .trap_return (trap_return),
      .mte         (mte),
      .mpte        (mpte)
   );

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
      dbg_trig_slot #(
         .ADDR_W    (ADDR_W),
         .MAX_BYTES (MAX_BYTES)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_cfg    (wr_cfg && sel_q == IDX_W'(i)),
         .wr_adr    (wr_adr && sel_q == IDX_W'(i)),
         .wdata     (csr_wdata),
         .dbg_mode  (dbg_mode),
         .set_hit   (fire && fire_idx == IDX_W'(i)),
         .acc_valid (acc_valid),
         .acc_addr  (acc_addr),
         .acc_size  (acc_size),
         .acc_load  (acc_load),
         .acc_store (acc_store),
         .acc_exec  (acc_exec),
         .acc_priv  (acc_priv),
         .mte       (mte),
         .cfg_q     (cfg_arr[i]),
         .adr_q     (adr_arr[i]),
         .hit_req   (req[i])
      );
      assign hit_vec[i] = cfg_arr[i][B_HIT];
   end

   dbg_trig_prio #(
      .N     (NUM_TRIG),
      .IDX_W (IDX_W)
   ) u_prio (
      .req (req),
      .any (fire),
      .idx (fire_idx)
   );

   assign fire_action = cfg_arr[fire_idx][AC_HI:AC_LO];
   assign sel_cfg     = cfg_arr[sel_q];

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         CSR_SEL: csr_rdata = 32'(sel_q);
         CSR_CFG: csr_rdata = sel_cfg;
         CSR_ADR: csr_rdata = 32'(adr_arr[sel_q]);
         CSR_CTL: begin
            csr_rdata[CTL_MTE]  = mte;
            csr_rdata[CTL_MPTE] = mpte;
         end
         default: csr_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk
   import dbg_trig_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                csr_we,
   input logic [11:0]         csr_addr,
   input logic                dbg_mode,
   input logic                trap_enter,
   input logic                trap_return,
   input logic                acc_valid,
   input logic [1:0]          acc_priv,
   input logic                fire,
   input logic [IDX_W-1:0]    fire_idx,
   input logic [3:0]          fire_action,
   input logic                mte,
   input logic                mpte,
   input logic [NUM_TRIG-1:0] hit_vec,
   input logic [31:0]         sel_cfg
);

   AST_NO_ACCESS_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !fire);  // R2

   AST_ACTION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> fire_action <= 4'd1);  // R4

   AST_HIT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> hit_vec[$past(fire_idx)]);  // R7

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == CSR_CFG && !dbg_mode && sel_cfg[B_DM] && !fire)
      |=> $stable(sel_cfg));  // R8

   AST_MACHINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && acc_priv == PRIV_M) |-> mte);  // R9

   AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> (!mte && mpte == $past(mte)));  // R10

   AST_TRAP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_return && !trap_enter) |=> (mte == $past(mpte)));  // R10

endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(
   .NUM_TRIG (NUM_TRIG),
   .IDX_W    (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_we      (csr_we),
   .csr_addr    (csr_addr),
   .dbg_mode    (dbg_mode),
   .trap_enter  (trap_enter),
   .trap_return (trap_return),
   .acc_valid   (acc_valid),
   .acc_priv    (acc_priv),
   .fire        (fire),
   .fire_idx    (fire_idx),
   .fire_action (fire_action),
   .mte         (mte),
   .mpte        (mpte),
   .hit_vec     (hit_vec),
   .sel_cfg     (sel_cfg)
);

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = 12'h7a0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        dbg_mode = 1'b0;
   logic        trap_enter = 1'b0;
   logic        trap_return = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_load = 1'b0;
   logic        acc_store = 1'b0;
   logic        acc_exec = 1'b0;
   logic [1:0]  acc_priv = 2'b11;
   logic        fire;
   logic [1:0]  fire_idx;
   logic [3:0]  fire_action;

   always #(CLK_P / 2) clk = ~clk;

   dbg_trig_unit dut_i (
      .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata, .dbg_mode,
      .trap_enter, .trap_return, .acc_valid, .acc_addr, .acc_size,
      .acc_load, .acc_store, .acc_exec, .acc_priv, .fire, .fire_idx, .fire_action
   );

   // Behavioural reference state
   logic [31:0] m_cfg [4];
   logic [31:0] m_adr [4];
   int          m_sel;
   logic        m_mte, m_mpte;
   int          n_chk = 0;
   int          n_err = 0;

   function automatic logic [31:0] m_legal(logic [31:0] wd, logic [31:0] cur, logic dbg);
      logic [31:0] r = '0;
      logic dm = dbg ? wd[27] : cur[27];
      int mt = int'(wd[10:7]);
      r = wd & 32'h0010_004F;
      r[10:7] = (mt > 1) ? 4'd1 : wd[10:7];
      if (wd[15:12] == 4'd1 && dm) r[12] = 1'b1;
      r[27] = dm;
      return r;
   endfunction

   function automatic logic m_match(int i);
      logic [31:0] c = m_cfg[i];
      logic [31:0] a = m_adr[i];
      int nb = (acc_size == 2'd0) ? 1 : (acc_size == 2'd1) ? 2 : 4;
      int z = 1;
      logic hit = 1'b0;
      if (!acc_valid) return 1'b0;
      if (!((acc_load && c[0]) || (acc_store && c[1]) || (acc_exec && c[2]))) return 1'b0;
      if (!((acc_priv == 2'b00 && c[3]) || (acc_priv == 2'b11 && c[6] && m_mte))) return 1'b0;
      while (z <= 32 && a[z-1]) z++;
      for (int b = 0; b < nb; b++) begin
         logic [31:0] ba = acc_addr + 32'(b);
         if (c[10:7] == 4'd1) begin
            if (z >= 32 || (ba >> z) == (a >> z)) hit = 1'b1;
         end else if (ba == a) hit = 1'b1;
      end
      return hit;
   endfunction

   task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // Compare this cycle's outputs, then advance the model at the edge.
   task automatic cyc(string tag);
      logic e_fire = 1'b0;
      int   e_idx = 0;
      logic [31:0] e_rd = '0;
      #1;
      for (int i = 3; i >= 0; i--) if (m_match(i)) begin e_fire = 1'b1; e_idx = i; end
      case (csr_addr)
         12'h7a0: e_rd = 32'(m_sel);
         12'h7a1: e_rd = m_cfg[m_sel];
         12'h7a2: e_rd = m_adr[m_sel];
         12'h7a5: begin e_rd[3] = m_mte; e_rd[7] = m_mpte; end
         default: e_rd = '0;
      endcase
      check(tag, "fire", 32'(fire), 32'(e_fire));
      if (e_fire) begin
         check(tag, "fire_idx", 32'(fire_idx), 32'(e_idx));
         check(tag, "fire_action", 32'(fire_action), 32'(m_cfg[e_idx][15:12]));
      end
      check(tag, "rdata", csr_rdata, e_rd);
      @(posedge clk);
      if (csr_we) begin
         case (csr_addr)
            12'h7a0: m_sel = int'(csr_wdata[1:0]);
            12'h7a1: if (!(m_cfg[m_sel][27] && !dbg_mode))
                        m_cfg[m_sel] = m_legal(csr_wdata, m_cfg[m_sel], dbg_mode);
            12'h7a2: if (!(m_cfg[m_sel][27] && !dbg_mode)) m_adr[m_sel] = csr_wdata;
            12'h7a5: if (!trap_enter && !trap_return) begin
                        m_mte = csr_wdata[3]; m_mpte = csr_wdata[7];
                     end
            default: ;
         endcase
      end
      if (trap_enter) begin m_mpte = m_mte; m_mte = 1'b0; end
      else if (trap_return) m_mte = m_mpte;
      if (e_fire) m_cfg[e_idx][20] = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, logic dbg, string tag);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d; dbg_mode = dbg;
      cyc(tag);
      csr_we = 1'b0; dbg_mode = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, string tag);
      csr_addr = a;
      cyc(tag);
   endtask

   task automatic acc(logic [31:0] a, logic [1:0] sz, logic [2:0] kind, logic [1:0] pv, string tag);
      acc_valid = 1'b1; acc_addr = a; acc_size = sz;
      {acc_exec, acc_store, acc_load} = kind; acc_priv = pv;
      cyc(tag);
      acc_valid = 1'b0; {acc_exec, acc_store, acc_load} = 3'b000;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_cfg[i] = '0; m_adr[i] = '0; end
      m_sel = 0; m_mte = 1'b0; m_mpte = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h7a0, "R1"); rd(12'h7a1, "R1"); rd(12'h7a2, "R1"); rd(12'h7a5, "R1");
      rd(12'h123, "R1");
      // R5 exact store trigger on index 1
      wr(12'h7a0, 32'h0000_0005, 1'b0, "R1");
      rd(12'h7a0, "R1");
      wr(12'h7a1, 32'h0000_0042, 1'b0, "R1");
      wr(12'h7a2, 32'h0000_1000, 1'b0, "R1");
      wr(12'h7a5, 32'h0000_0008, 1'b0, "R9");
      acc(32'h0000_0ffe, 2'd2, 3'b010, 2'b11, "R5");
      acc(32'h0000_1001, 2'd0, 3'b010, 2'b11, "R5");
      acc(32'h0000_0fff, 2'd1, 3'b010, 2'b11, "R5");
      acc(32'h0000_0ffc, 2'd2, 3'b010, 2'b11, "R5");
      acc(32'h0000_1000, 2'd0, 3'b001, 2'b11, "R2");
      acc(32'h0000_1000, 2'd0, 3'b100, 2'b11, "R2");
      acc(32'h0000_1000, 2'd0, 3'b010, 2'b00, "R2");
      acc(32'h0000_1000, 2'd0, 3'b010, 2'b01, "R2");
      rd(12'h7a1, "R7");
      // R9 machine gate
      wr(12'h7a5, 32'h0, 1'b0, "R9");
      acc(32'h0000_1000, 2'd0, 3'b010, 2'b11, "R9");
      // R6 region on index 2 (16 bytes at 0x2000)
      wr(12'h7a0, 32'h2, 1'b0, "R6");
      wr(12'h7a1, 32'h0000_00c9, 1'b0, "R6");
      wr(12'h7a2, 32'h0000_2007, 1'b0, "R6");
      acc(32'h0000_2000, 2'd0, 3'b001, 2'b00, "R6");
      acc(32'h0000_200f, 2'd0, 3'b001, 2'b00, "R6");
      acc(32'h0000_2010, 2'd2, 3'b001, 2'b00, "R6");
      acc(32'h0000_1ffe, 2'd2, 3'b001, 2'b00, "R6");
      acc(32'h0000_1ffb, 2'd2, 3'b001, 2'b00, "R6");
      acc(32'h0000_2008, 2'd0, 3'b001, 2'b11, "R9");
      wr(12'h7a2, 32'h0000_2005, 1'b0, "R6");
      acc(32'h0000_2007, 2'd0, 3'b001, 2'b00, "R6");
      acc(32'h0000_2008, 2'd0, 3'b001, 2'b00, "R6");
      wr(12'h7a2, 32'hffff_ffff, 1'b0, "R6");
      acc(32'h8765_4321, 2'd0, 3'b001, 2'b00, "R6");
      wr(12'h7a2, 32'h0000_2007, 1'b0, "R6");
      // R11 priority: index 0 exact on 0x2004 overlaps index 2 region
      wr(12'h7a1, 32'h0000_00c9, 1'b0, "R7");
      wr(12'h7a0, 32'h0, 1'b0, "R11");
      wr(12'h7a1, 32'h0000_0049, 1'b0, "R11");
      wr(12'h7a2, 32'h0000_2004, 1'b0, "R11");
      acc(32'h0000_2004, 2'd0, 3'b001, 2'b00, "R11");
      rd(12'h7a1, "R11");
      wr(12'h7a0, 32'h2, 1'b0, "R11");
      rd(12'h7a1, "R11");
      acc(32'hffff_fffe, 2'd2, 3'b001, 2'b00, "R5");
      // R7 hit clear and same-cycle clear plus fire
      wr(12'h7a0, 32'h0, 1'b0, "R7");
      wr(12'h7a1, 32'h0000_0049, 1'b0, "R7");
      rd(12'h7a1, "R7");
      csr_we = 1'b1; csr_wdata = 32'h0000_0049; csr_addr = 12'h7a1;
      acc(32'h0000_2004, 2'd0, 3'b001, 2'b00, "R7");
      csr_we = 1'b0;
      rd(12'h7a1, "R7");
      // R3 / R4 legalisation
      wr(12'h7a1, 32'h0000_0a49, 1'b0, "R3");
      rd(12'h7a1, "R3");
      wr(12'h7a1, 32'h0000_1049, 1'b0, "R4");
      rd(12'h7a1, "R4");
      wr(12'h7a1, 32'h0000_3049, 1'b1, "R4");
      rd(12'h7a1, "R4");
      wr(12'h7a1, 32'h0800_1049, 1'b1, "R4");
      rd(12'h7a1, "R4");
      acc(32'h0000_2004, 2'd0, 3'b001, 2'b00, "R4");
      // R8 lock
      wr(12'h7a1, 32'h0, 1'b0, "R8");
      rd(12'h7a1, "R8");
      wr(12'h7a2, 32'h0000_3000, 1'b0, "R8");
      rd(12'h7a2, "R8");
      acc(32'h0000_2004, 2'd0, 3'b001, 2'b00, "R8");
      wr(12'h7a2, 32'h0000_3000, 1'b1, "R8");
      rd(12'h7a2, "R8");
      wr(12'h7a1, 32'h0000_0049, 1'b1, "R8");
      rd(12'h7a1, "R8");
      wr(12'h7a1, 32'h0800_0049, 1'b0, "R8");
      rd(12'h7a1, "R8");
      // R10 trap save / restore, trap beats CSR write
      wr(12'h7a5, 32'h0000_0008, 1'b0, "R10");
      trap_enter = 1'b1; rd(12'h7a5, "R10"); trap_enter = 1'b0;
      rd(12'h7a5, "R10");
      trap_return = 1'b1; rd(12'h7a5, "R10"); trap_return = 1'b0;
      rd(12'h7a5, "R10");
      csr_we = 1'b1; csr_wdata = 32'h0; trap_enter = 1'b1;
      rd(12'h7a5, "R10");
      csr_we = 1'b0; trap_enter = 1'b0;
      rd(12'h7a5, "R10");
      csr_we = 1'b1; csr_wdata = 32'h0; trap_return = 1'b1;
      rd(12'h7a5, "R10");
      csr_we = 1'b0; trap_return = 1'b0;
      rd(12'h7a5, "R10");
      // R12 all-zero config disables
      wr(12'h7a0, 32'h2, 1'b0, "R12");
      wr(12'h7a1, 32'h0, 1'b0, "R12");
      acc(32'h0000_2004, 2'd0, 3'b111, 2'b00, "R12");
      acc(32'h0000_2004, 2'd0, 3'b111, 2'b11, "R12");
      rd(12'h7a1, "R12");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule